// File: doc/BRIEF.md
# Framed serial word receiver

This block is the receive half of a slave serial link. A partner device supplies a bit clock, a frame-sync pulse and a data line. On every falling edge of that bit clock the receiver samples the sync and the data. A sync seen while the receiver is idle starts a frame. The data line carries no bit on that edge. The next sixteen falling edges each deliver one bit, most significant bit first, with no companding. When the sixteenth bit arrives, the assembled word is copied into a holding register and a ready flag is raised.

A host in the local clock domain reads the word from the holding register. It then pulses a read strobe, which clears the ready flag. All three serial inputs pass through a synchronizer chain into the local clock, so the local clock must run several times faster than the bit clock. A sync pulse that arrives while a word is still shifting in is ignored. If a second word completes before the first has been read, the new word replaces the old one and an overrun flag is set. The overrun flag stays set until the next read strobe.

Top module: `srx_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_ready` is 0, `overrun` is 0 and `rd_data` is 0.
- R2: A frame delivers WORD_W = 16 data bits, most significant bit first. After the last bit is sampled, `rd_data` holds that word and `rx_ready` is 1.
- R3: The data line is not sampled on the falling edge where the sync is seen. The first data bit (the MSB) is taken on the following falling edge, which is a 1-bit data delay.
- R4: Sync and data are sampled only at falling edges of `sclk_in`. Data values present at the rising edge, or elsewhere in the high phase before the fall, have no effect.
- R5: A sync pulse during bits MSB to bit 1 of a word is ignored. The word in progress completes at its own sixteenth bit, and no extra word follows.
- R6: While idle, falling edges without a sync capture nothing, and `rx_ready` stays 0.
- R7: A cycle with `rd_stb` high and no word completing leaves `rx_ready` at 0 on the next cycle. A strobe while `rx_ready` is 0 changes nothing.
- R8: A word that completes while `rx_ready` is 1 and `rd_stb` is low sets `overrun` to 1 and overwrites `rd_data` with the new word. `rx_ready` stays 1.
- R9: If `rd_stb` is high in the same cycle that a word completes, the new word is loaded, `rx_ready` stays 1 and `overrun` is not set.
- R10: A read strobe clears `overrun`.
- R11: A sync on the edge that carries bit 0 is ignored. A sync on the very next falling edge starts a new frame, so frames can follow each other with a 17-edge period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Bit clock from the partner; sampling happens on its falling edge |
| fsync_in | input | 1 | Frame sync from the partner, active high for one bit period |
| sdata_in | input | 1 | Serial data, MSB first |
| rd_stb | input | 1 | Host read strobe, one local cycle |
| rd_data | output | WORD_W | Holding register |
| rx_ready | output | 1 | A new word is waiting in the holding register |
| overrun | output | 1 | A word was overwritten before it was read |

## Verification
Two events can fall in the same local cycle: a word completing into the holding register, and the host strobing a read. The bench first leaves one word unread. It then places the read strobe on the exact cycle the second word completes, which is the third local edge after the synchronized bit-clock fall. A correct block keeps the ready flag high, loads the new word and does not raise overrun. The bench also checks the opposite case: a completion without any read must raise overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic fsync_in,
  input  logic sdata_in,
  output logic fall_pulse,
  output logic fs_s,
  output logic sd_s
);
  // bit 2: clock, bit 1: sync, bit 0: data
  logic [2:0] stage_q [SYNC_STAGES];
  logic       clk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= 3'b000;
    else     stage_q[0] <= {sclk_in, fsync_in, sdata_in};
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= 3'b000;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_prev_q <= 1'b0;
    else     clk_prev_q <= stage_q[SYNC_STAGES-1][2];
  end

  assign fall_pulse = clk_prev_q & ~stage_q[SYNC_STAGES-1][2];
  assign fs_s       = stage_q[SYNC_STAGES-1][1];
  assign sd_s       = stage_q[SYNC_STAGES-1][0];

  // R4: a detected fall cannot repeat on the next cycle
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_pulse,
  input  logic              fs_s,
  input  logic              sd_s,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_next;

  assign sr_next = {sr_q[WORD_W-2:0], sd_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      word_done <= 1'b0;
      word_q    <= '0;
    end else begin
      word_done <= 1'b0;
      if (fall_pulse) begin
        unique case (state_q)
          RX_IDLE: begin
            if (fs_s) begin
              state_q <= RX_SHIFT;
              cnt_q   <= '0;
            end
          end
          RX_SHIFT: begin
            sr_q <= sr_next;
            if (cnt_q == LAST_BIT) begin
              state_q   <= RX_IDLE;
              word_done <= 1'b1;
              word_q    <= sr_next;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R5: a sync pulse mid-word must not drop the shift state back to idle
  midword_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_SHIFT && fall_pulse && cnt_q != LAST_BIT) |=> state_q == RX_SHIFT);

  // R6: a word can only complete out of the shift state
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(state_q) == RX_SHIFT);

  // R2: completion pulses never last more than one cycle
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_q,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (word_done) begin
        rd_data  <= word_q;
        rx_ready <= 1'b1;
      end else if (rd_stb) begin
        rx_ready <= 1'b0;
      end
      if (word_done && rx_ready && !rd_stb) overrun <= 1'b1;
      else if (rd_stb)                      overrun <= 1'b0;
    end
  end

  // R2: a completed word lands in the holding register
  load_word_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> (rx_ready && rd_data == $past(word_q)));

  // R7: a read with no completion empties the register
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !word_done) |=> !rx_ready);

  // R8: an unread word that is overwritten raises overrun
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && rx_ready && !rd_stb) |=> overrun);

  // R9: a read in the completion cycle avoids overrun
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && rd_stb) |=> (rx_ready && !overrun));

  // R10: a read clears overrun
  overrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !overrun);
endmodule

// File: rtl/srx_top.sv
module srx_top #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              overrun
);
  logic              fall_pulse;
  logic              fs_s;
  logic              sd_s;
  logic              word_done;
  logic [WORD_W-1:0] word_q;

  srx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sclk_in    (sclk_in),
    .fsync_in   (fsync_in),
    .sdata_in   (sdata_in),
    .fall_pulse (fall_pulse),
    .fs_s       (fs_s),
    .sd_s       (sd_s)
  );

  srx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .fall_pulse (fall_pulse),
    .fs_s       (fs_s),
    .sd_s       (sd_s),
    .word_done  (word_done),
    .word_q     (word_q)
  );

  srx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word_q    (word_q),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .rx_ready  (rx_ready),
    .overrun   (overrun)
  );

  // R1: nothing is pending on the cycle after reset
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_ready && !overrun && rd_data == '0));
endmodule

// File: tb/srx_top_test.sv
`timescale 1ns/1ps
module srx_top_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk_in = 1'b0;
  logic         fsync_in = 1'b0;
  logic         sdata_in = 1'b0;
  logic         rd_stb = 1'b0;
  logic [W-1:0] rd_data;
  logic         rx_ready;
  logic         overrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  srx_top #(.WORD_W(W), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .rst      (rst),
    .sclk_in  (sclk_in),
    .fsync_in (fsync_in),
    .sdata_in (sdata_in),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .rx_ready (rx_ready),
    .overrun  (overrun)
  );

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // high phase: wrong data at the rise, true data shortly before the fall
  task automatic rise_phase(input logic b, input logic f);
    @(negedge clk);
    sclk_in = 1'b1; fsync_in = f; sdata_in = ~b;
    repeat (3) @(negedge clk);
    sdata_in = b;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic tick(input logic b, input logic f);
    rise_phase(b, f);
    repeat (8) @(negedge clk);
  endtask

  task automatic send_frame(input logic [W-1:0] w, input int mid_sync, input logic last_sync);
    tick(~w[W-1], 1'b1);
    for (int i = W - 1; i >= 0; i--)
      tick(w[i], (i == mid_sync) || (i == 0 && last_sync));
  endtask

  task automatic do_read(output logic [W-1:0] d);
    @(negedge clk);
    d = rd_data;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!rx_ready && !overrun && rd_data == '0, "R1 state in reset", {rx_ready, overrun, rd_data[13:0]}, '0);
    @(negedge clk); rst = 1'b0;
    chk(!rx_ready && !overrun && rd_data == '0, "R1 state after reset", {rx_ready, overrun, rd_data[13:0]}, '0);
  endtask

  task automatic t_basic;
    logic [W-1:0] d;
    send_frame(16'hA5C3, -1, 1'b0);
    chk(rx_ready, "R2 ready after word", {15'd0, rx_ready}, 16'd1);
    chk(rd_data == 16'hA5C3, "R2 MSB-first word", rd_data, 16'hA5C3);
    chk(rd_data == 16'hA5C3, "R4 falling-edge sampling", rd_data, 16'hA5C3);
    do_read(d);
    @(negedge clk);
    chk(!rx_ready, "R7 read clears ready", {15'd0, rx_ready}, 16'd0);
  endtask

  task automatic t_delay;
    logic [W-1:0] d;
    send_frame(16'h1234, -1, 1'b0);
    chk(rd_data == 16'h1234, "R3 one-bit data delay", rd_data, 16'h1234);
    do_read(d);
    send_frame(16'hFFFE, -1, 1'b0);
    chk(rd_data == 16'hFFFE, "R3 delay with high MSB", rd_data, 16'hFFFE);
    do_read(d);
  endtask

  task automatic t_idle;
    logic [W-1:0] d;
    for (int i = 0; i < 20; i++) tick(i[0], 1'b0);
    chk(!rx_ready, "R6 no capture while idle", {15'd0, rx_ready}, 16'd0);
    do_read(d);
    @(negedge clk);
    chk(!rx_ready && !overrun, "R7 strobe while empty has no effect",
        {14'd0, rx_ready, overrun}, 16'd0);
  endtask

  task automatic t_midsync;
    logic [W-1:0] d;
    send_frame(16'h5A0F, 10, 1'b0);
    chk(rd_data == 16'h5A0F && rx_ready, "R5 mid-word sync ignored", rd_data, 16'h5A0F);
    do_read(d);
    for (int i = 0; i < 18; i++) tick(1'b1, 1'b0);
    chk(!rx_ready, "R5 no restarted word", {15'd0, rx_ready}, 16'd0);
  endtask

  task automatic t_back_to_back;
    logic [W-1:0] d;
    send_frame(16'h00FF, -1, 1'b1);
    chk(rd_data == 16'h00FF, "R11 first word", rd_data, 16'h00FF);
    do_read(d);
    send_frame(16'hC3A5, -1, 1'b0);
    chk(rd_data == 16'hC3A5 && rx_ready, "R11 next frame on next edge", rd_data, 16'hC3A5);
    do_read(d);
  endtask

  task automatic t_overrun;
    logic [W-1:0] d;
    send_frame(16'h1111, -1, 1'b0);
    send_frame(16'h2222, -1, 1'b0);
    chk(overrun, "R8 overrun set", {15'd0, overrun}, 16'd1);
    chk(rd_data == 16'h2222 && rx_ready, "R8 word overwritten", rd_data, 16'h2222);
    do_read(d);
    @(negedge clk);
    chk(!overrun && !rx_ready, "R10 read clears overrun", {14'd0, rx_ready, overrun}, 16'd0);
  endtask

  task automatic t_same_cycle;
    logic [W-1:0] d;
    logic [W-1:0] w2;
    w2 = 16'h9E37;
    send_frame(16'h4444, -1, 1'b0);
    tick(1'b0, 1'b1);
    for (int i = W - 1; i >= 1; i--) tick(w2[i], 1'b0);
    rise_phase(w2[0], 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(rx_ready, "R9 ready kept on same-cycle read", {15'd0, rx_ready}, 16'd1);
    chk(!overrun, "R9 no overrun on same-cycle read", {15'd0, overrun}, 16'd0);
    chk(rd_data == w2, "R9 new word loaded", rd_data, w2);
    do_read(d);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_delay();
    t_idle();
    t_midsync();
    t_back_to_back();
    t_overrun();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule